// File: doc/BRIEF.md
# Fetch Redirect and Interrupt Vectoring

This block sits between the execute stage and instruction fetch of a 64-bit in-order core. In each cycle it gathers the requests that can steer fetch: a mispredicted branch, a context-synchronising instruction, a return from interrupt, a synchronous exception and an asynchronous interrupt. It picks one of them by priority and registers a compact description of the redirect: a state, a 12-bit vector, a 64-bit offset, an absolute flag and four fetch mode bits. It also registers the address of the last valid instruction.

In the cycle after that it builds the fetch address and the fetch mode from those registers. Interrupts use the vector directly, zero-extended to 64 bits, and force a fixed supervisor mode. Other redirects either use the offset as an absolute target or add it to the registered instruction address. The addition comes after the register, so it is not on the execute stage's critical path.

The registered state has three values, and they decide what fetch sees:
- RUN: no redirect.
- STEER: an instruction-driven redirect.
- VECTOR: an interrupt redirect.

The block moves to VECTOR when an exception is requested, or when an enabled asynchronous source is pending. It moves to STEER when a valid instruction is a return from interrupt, a context sync or a mispredicted branch. It goes to RUN in every other cycle. No state holds itself, so each redirect lasts one cycle unless it is requested again.

Top module: `fetch_redirect_gen`

## Requirements
- R1: After reset, `fetch_redirect`, `busy` and `valid_out` are 0, `fetch_addr` is 0 and all four mode outputs are 0.
- R2: A valid resolved branch whose outcome differs from its prediction, with the prediction not-taken and `br_abs`=0, drives `fetch_redirect`=1 in the next cycle. In that cycle `fetch_addr` = `cur_nia` + `br_operand` modulo 2^64.
- R3: The same mispredict with `br_abs`=1 gives `fetch_addr` = `br_operand`.
- R4: A branch predicted taken but resolved not-taken redirects to `cur_nia`+4. A branch whose outcome matches its prediction causes no redirect.
- R5: A valid context-sync request redirects to `cur_nia`+4 modulo 2^64.
- R6: With no interrupt, the mode outputs follow, one cycle later, the current state bits: `fetch_virt`=`cur_ir`, `fetch_priv`=!`cur_pr`, `fetch_big_end`=!`cur_le`, `fetch_narrow`=!`cur_sf`.
- R7: A valid return-from-interrupt redirects to `rfi_addr`. Its mode outputs are `fetch_virt`=`rfi_ir`|`rfi_pr`, `fetch_priv`=!`rfi_pr`, `fetch_big_end`=!`rfi_le` and `fetch_narrow`=!`rfi_sf`.
- R8: With `exc_req`=1, the next cycle redirects to the vector selected by `exc_cause`, and the mode is forced to virt=0, priv=1, big_end=0, narrow=0. The cause codes and vectors are:
  - 0: program, 0x700
  - 1: FP unavailable, 0x800
  - 2: system call, 0xC00
  - 3: trace, 0xD00
  - 4: alignment, 0x600
  - 5: data storage, 0x300
  - 6: data segment, 0x380
  - 7: instruction storage, 0x400
  - 8: instruction segment, 0x480
  - any other code: 0x700
- R9: Asynchronous interrupts are taken only when `cur_ee`=1. A pending `dec_top` goes to 0x900 and wins over `ext_irq`. `ext_irq` alone goes to 0x500. With `cur_ee`=0, neither source has any effect on the outputs.
- R10: The priority is, from highest to lowest: exception, then enabled asynchronous interrupt, then return from interrupt, then context sync, then mispredict.
- R11: `busy` equals `fetch_redirect`. `valid_out` is the previous cycle's `op_valid`, forced to 0 when a redirect is issued. A redirect lasts exactly one cycle unless it is requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute stage holds a valid instruction |
| cur_nia | input | 64 | Address of that instruction |
| cur_ir | input | 1 | Current translation-enable bit |
| cur_pr | input | 1 | Current problem-state (user) bit |
| cur_le | input | 1 | Current little-endian bit |
| cur_sf | input | 1 | Current 64-bit mode bit |
| cur_ee | input | 1 | Current external-interrupt enable |
| br_resolve | input | 1 | Instruction is a resolved conditional branch |
| br_taken | input | 1 | Resolved outcome |
| br_pred_taken | input | 1 | Predicted outcome |
| br_abs | input | 1 | Branch target is absolute |
| br_operand | input | 64 | Branch displacement or absolute target |
| csync_req | input | 1 | Context-synchronising instruction |
| rfi_req | input | 1 | Return-from-interrupt instruction |
| rfi_addr | input | 64 | Return target address |
| rfi_ir | input | 1 | Restored translation bit |
| rfi_pr | input | 1 | Restored problem-state bit |
| rfi_le | input | 1 | Restored little-endian bit |
| rfi_sf | input | 1 | Restored 64-bit mode bit |
| dec_top | input | 1 | Decrementer sign bit (pending) |
| ext_irq | input | 1 | External interrupt pending |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 4 | Exception cause code |
| fetch_redirect | output | 1 | Redirect fetch this cycle |
| fetch_addr | output | 64 | Redirect target |
| fetch_virt | output | 1 | Fetch with translation |
| fetch_priv | output | 1 | Fetch privileged |
| fetch_big_end | output | 1 | Fetch big-endian |
| fetch_narrow | output | 1 | Fetch in 32-bit mode |
| busy | output | 1 | Execute stalled by the redirect |
| valid_out | output | 1 | Registered instruction valid to writeback |

## Verification
Branch targets are tried with a negative relative displacement, an absolute target with the high bit set, and a predicted-taken miss. These separate the adder path from the absolute path and the +4 path. A context sync at the top of the address space shows that the sum wraps. Each exception cause is run with translation enabled, which shows that the vector and the forced mode both come from the cause table. Simultaneous requests (an exception with a mispredict, and a decrementer with a context sync), together with the enable cases, show the priority and the gating.

// File: rtl/redir_pkg.sv
package redir_pkg;

    localparam int XLEN    = 64;
    localparam int VEC_W   = 12;
    localparam int CAUSE_W = 4;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STEER  = 2'd1,
        ST_VECTOR = 2'd2
    } redir_state_e;

    typedef struct packed {
        logic virt;
        logic priv;
        logic big_end;
        logic narrow;
    } fetch_mode_t;

    localparam logic [CAUSE_W-1:0] CS_PROGRAM = 4'd0;
    localparam logic [CAUSE_W-1:0] CS_FPU_OFF = 4'd1;
    localparam logic [CAUSE_W-1:0] CS_SYSCALL = 4'd2;
    localparam logic [CAUSE_W-1:0] CS_TRACE   = 4'd3;
    localparam logic [CAUSE_W-1:0] CS_ALIGN   = 4'd4;
    localparam logic [CAUSE_W-1:0] CS_DSTORE  = 4'd5;
    localparam logic [CAUSE_W-1:0] CS_DSEG    = 4'd6;
    localparam logic [CAUSE_W-1:0] CS_ISTORE  = 4'd7;
    localparam logic [CAUSE_W-1:0] CS_ISEG    = 4'd8;

    localparam logic [VEC_W-1:0] VEC_DEC = 12'h900;
    localparam logic [VEC_W-1:0] VEC_EXT = 12'h500;

    function automatic logic [VEC_W-1:0] cause_vector(input logic [CAUSE_W-1:0] c);
        logic [VEC_W-1:0] v;
        unique case (c)
            CS_FPU_OFF: v = 12'h800;
            CS_SYSCALL: v = 12'hC00;
            CS_TRACE:   v = 12'hD00;
            CS_ALIGN:   v = 12'h600;
            CS_DSTORE:  v = 12'h300;
            CS_DSEG:    v = 12'h380;
            CS_ISTORE:  v = 12'h400;
            CS_ISEG:    v = 12'h480;
            default:    v = 12'h700;
        endcase
        return v;
    endfunction

    function automatic fetch_mode_t mode_of(input logic ir, input logic pr,
                                            input logic le, input logic sf,
                                            input logic returning);
        fetch_mode_t m;
        m.virt    = ir | (returning & pr);
        m.priv    = ~pr;
        m.big_end = ~le;
        m.narrow  = ~sf;
        return m;
    endfunction

    localparam fetch_mode_t MODE_TRAP = '{virt: 1'b0, priv: 1'b1, big_end: 1'b0, narrow: 1'b0};

endpackage

// File: rtl/redir_arbiter.sv
module redir_arbiter
    import redir_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int VW = VEC_W,
    parameter int CW = CAUSE_W
) (
    input  logic          op_valid,
    input  logic          cur_ir,
    input  logic          cur_pr,
    input  logic          cur_le,
    input  logic          cur_sf,
    input  logic          cur_ee,
    input  logic          br_resolve,
    input  logic          br_taken,
    input  logic          br_pred_taken,
    input  logic          br_abs,
    input  logic [AW-1:0] br_operand,
    input  logic          csync_req,
    input  logic          rfi_req,
    input  logic [AW-1:0] rfi_addr,
    input  logic          rfi_ir,
    input  logic          rfi_pr,
    input  logic          rfi_le,
    input  logic          rfi_sf,
    input  logic          dec_top,
    input  logic          ext_irq,
    input  logic          exc_req,
    input  logic [CW-1:0] exc_cause,
    output redir_state_e  nxt_state,
    output logic          nxt_abs,
    output logic [VW-1:0] nxt_vector,
    output logic [AW-1:0] nxt_offset,
    output fetch_mode_t   nxt_mode
);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic async_hit;
    logic mispredict;

    assign async_hit  = cur_ee & (dec_top | ext_irq);
    assign mispredict = op_valid & br_resolve & (br_taken != br_pred_taken);

    always_comb begin
        nxt_state  = ST_RUN;
        nxt_abs    = 1'b0;
        nxt_vector = '0;
        nxt_offset = '0;
        nxt_mode   = mode_of(cur_ir, cur_pr, cur_le, cur_sf, 1'b0);
        if (exc_req) begin
            nxt_state  = ST_VECTOR;
            nxt_vector = VW'(cause_vector(CAUSE_W'(exc_cause)));
        end else if (async_hit) begin
            nxt_state  = ST_VECTOR;
            nxt_vector = dec_top ? VW'(VEC_DEC) : VW'(VEC_EXT);
        end else if (op_valid && rfi_req) begin
            nxt_state  = ST_STEER;
            nxt_abs    = 1'b1;
            nxt_offset = rfi_addr;
            nxt_mode   = mode_of(rfi_ir, rfi_pr, rfi_le, rfi_sf, 1'b1);
        end else if (op_valid && csync_req) begin
            nxt_state  = ST_STEER;
            nxt_offset = STEP;
        end else if (mispredict) begin
            nxt_state = ST_STEER;
            if (br_pred_taken) begin
                nxt_offset = STEP;
            end else begin
                nxt_offset = br_operand;
                nxt_abs    = br_abs;
            end
        end
    end

endmodule

// File: rtl/redir_state_reg.sv
module redir_state_reg
    import redir_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [AW-1:0] cur_nia,
    input  redir_state_e  nxt_state,
    input  logic          nxt_abs,
    input  logic [VW-1:0] nxt_vector,
    input  logic [AW-1:0] nxt_offset,
    input  fetch_mode_t   nxt_mode,
    output redir_state_e  state_q,
    output logic          abs_q,
    output logic [VW-1:0] vector_q,
    output logic [AW-1:0] offset_q,
    output fetch_mode_t   mode_q,
    output logic [AW-1:0] last_q,
    output logic          busy_q,
    output logic          valid_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= nxt_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abs_q    <= 1'b0;
            vector_q <= '0;
            offset_q <= '0;
            mode_q   <= '0;
            last_q   <= '0;
            busy_q   <= 1'b0;
            valid_q  <= 1'b0;
        end else begin
            abs_q    <= nxt_abs;
            vector_q <= nxt_vector;
            offset_q <= nxt_offset;
            mode_q   <= nxt_mode;
            if (op_valid) last_q <= cur_nia;
            busy_q   <= (nxt_state != ST_RUN);
            valid_q  <= op_valid & (nxt_state == ST_RUN);
        end
    end

    // R11: the state never holds a redirect without a fresh request.
    assert_steer_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_state == ST_RUN) |=> (state_q == ST_RUN) && !busy_q);

endmodule

// File: rtl/redir_target.sv
module redir_target
    import redir_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int VW = VEC_W
) (
    input  redir_state_e  state_q,
    input  logic          abs_q,
    input  logic [VW-1:0] vector_q,
    input  logic [AW-1:0] offset_q,
    input  fetch_mode_t   mode_q,
    input  logic [AW-1:0] last_q,
    output logic          redirect,
    output logic [AW-1:0] addr,
    output fetch_mode_t   mode
);
    logic [AW-1:0] rel_sum;

    assign rel_sum = last_q + offset_q;

    always_comb begin
        unique case (state_q)
            ST_VECTOR: begin
                redirect = 1'b1;
                addr     = AW'(vector_q);
                mode     = MODE_TRAP;
            end
            ST_STEER: begin
                redirect = 1'b1;
                addr     = abs_q ? offset_q : rel_sum;
                mode     = mode_q;
            end
            default: begin
                redirect = 1'b0;
                addr     = abs_q ? offset_q : rel_sum;
                mode     = mode_q;
            end
        endcase
    end

endmodule

// File: rtl/fetch_redirect_gen.sv
module fetch_redirect_gen
    import redir_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int VW = VEC_W,
    parameter int CW = CAUSE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [AW-1:0] cur_nia,
    input  logic          cur_ir,
    input  logic          cur_pr,
    input  logic          cur_le,
    input  logic          cur_sf,
    input  logic          cur_ee,
    input  logic          br_resolve,
    input  logic          br_taken,
    input  logic          br_pred_taken,
    input  logic          br_abs,
    input  logic [AW-1:0] br_operand,
    input  logic          csync_req,
    input  logic          rfi_req,
    input  logic [AW-1:0] rfi_addr,
    input  logic          rfi_ir,
    input  logic          rfi_pr,
    input  logic          rfi_le,
    input  logic          rfi_sf,
    input  logic          dec_top,
    input  logic          ext_irq,
    input  logic          exc_req,
    input  logic [CW-1:0] exc_cause,
    output logic          fetch_redirect,
    output logic [AW-1:0] fetch_addr,
    output logic          fetch_virt,
    output logic          fetch_priv,
    output logic          fetch_big_end,
    output logic          fetch_narrow,
    output logic          busy,
    output logic          valid_out
);
    redir_state_e  nxt_state, state_q;
    logic          nxt_abs, abs_q;
    logic [VW-1:0] nxt_vector, vector_q;
    logic [AW-1:0] nxt_offset, offset_q, last_q;
    fetch_mode_t   nxt_mode, mode_q, mode_out;

    redir_arbiter #(.AW(AW), .VW(VW), .CW(CW)) u_arb (
        .op_valid(op_valid), .cur_ir(cur_ir), .cur_pr(cur_pr), .cur_le(cur_le),
        .cur_sf(cur_sf), .cur_ee(cur_ee), .br_resolve(br_resolve),
        .br_taken(br_taken), .br_pred_taken(br_pred_taken), .br_abs(br_abs),
        .br_operand(br_operand), .csync_req(csync_req), .rfi_req(rfi_req),
        .rfi_addr(rfi_addr), .rfi_ir(rfi_ir), .rfi_pr(rfi_pr), .rfi_le(rfi_le),
        .rfi_sf(rfi_sf), .dec_top(dec_top), .ext_irq(ext_irq),
        .exc_req(exc_req), .exc_cause(exc_cause),
        .nxt_state(nxt_state), .nxt_abs(nxt_abs), .nxt_vector(nxt_vector),
        .nxt_offset(nxt_offset), .nxt_mode(nxt_mode)
    );

    redir_state_reg #(.AW(AW), .VW(VW)) u_state (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cur_nia(cur_nia),
        .nxt_state(nxt_state), .nxt_abs(nxt_abs), .nxt_vector(nxt_vector),
        .nxt_offset(nxt_offset), .nxt_mode(nxt_mode),
        .state_q(state_q), .abs_q(abs_q), .vector_q(vector_q),
        .offset_q(offset_q), .mode_q(mode_q), .last_q(last_q),
        .busy_q(busy), .valid_q(valid_out)
    );

    redir_target #(.AW(AW), .VW(VW)) u_tgt (
        .state_q(state_q), .abs_q(abs_q), .vector_q(vector_q),
        .offset_q(offset_q), .mode_q(mode_q), .last_q(last_q),
        .redirect(fetch_redirect), .addr(fetch_addr), .mode(mode_out)
    );

    assign fetch_virt    = mode_out.virt;
    assign fetch_priv    = mode_out.priv;
    assign fetch_big_end = mode_out.big_end;
    assign fetch_narrow  = mode_out.narrow;

    logic async_pend;
    assign async_pend = cur_ee & (dec_top | ext_irq);

    assert_exc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> fetch_redirect && (fetch_addr >> VW) == '0 && fetch_priv && !fetch_virt);

    assert_ee_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_ee && !exc_req && !(op_valid && (rfi_req || csync_req || br_resolve)))
        |=> !fetch_redirect);

    assert_squash_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |-> busy && !valid_out);

    assert_csync_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && csync_req && !rfi_req && !exc_req && !async_pend)
        |=> fetch_redirect && fetch_addr == $past(cur_nia) + AW'(4));

    assert_abs_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && br_resolve && br_taken && !br_pred_taken && br_abs &&
         !csync_req && !rfi_req && !exc_req && !async_pend)
        |=> fetch_redirect && fetch_addr == $past(br_operand));

endmodule

// File: tb/fetch_redirect_gen_test.sv
module fetch_redirect_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [63:0] cur_nia;
    logic        cur_ir, cur_pr, cur_le, cur_sf, cur_ee;
    logic        br_resolve, br_taken, br_pred_taken, br_abs;
    logic [63:0] br_operand;
    logic        csync_req, rfi_req;
    logic [63:0] rfi_addr;
    logic        rfi_ir, rfi_pr, rfi_le, rfi_sf;
    logic        dec_top, ext_irq, exc_req;
    logic [3:0]  exc_cause;
    logic        fetch_redirect;
    logic [63:0] fetch_addr;
    logic        fetch_virt, fetch_priv, fetch_big_end, fetch_narrow;
    logic        busy, valid_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    fetch_redirect_gen uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cur_nia(cur_nia),
        .cur_ir(cur_ir), .cur_pr(cur_pr), .cur_le(cur_le), .cur_sf(cur_sf),
        .cur_ee(cur_ee), .br_resolve(br_resolve), .br_taken(br_taken),
        .br_pred_taken(br_pred_taken), .br_abs(br_abs), .br_operand(br_operand),
        .csync_req(csync_req), .rfi_req(rfi_req), .rfi_addr(rfi_addr),
        .rfi_ir(rfi_ir), .rfi_pr(rfi_pr), .rfi_le(rfi_le), .rfi_sf(rfi_sf),
        .dec_top(dec_top), .ext_irq(ext_irq), .exc_req(exc_req),
        .exc_cause(exc_cause), .fetch_redirect(fetch_redirect),
        .fetch_addr(fetch_addr), .fetch_virt(fetch_virt), .fetch_priv(fetch_priv),
        .fetch_big_end(fetch_big_end), .fetch_narrow(fetch_narrow),
        .busy(busy), .valid_out(valid_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    function automatic logic [3:0] mode_now();
        return {fetch_virt, fetch_priv, fetch_big_end, fetch_narrow};
    endfunction

    task automatic idle();
        op_valid = 0; cur_nia = 0; br_resolve = 0; br_taken = 0; br_pred_taken = 0;
        br_abs = 0; br_operand = 0; csync_req = 0; rfi_req = 0; rfi_addr = 0;
        rfi_ir = 0; rfi_pr = 0; rfi_le = 0; rfi_sf = 0; dec_top = 0; ext_irq = 0;
        exc_req = 0; exc_cause = 0;
    endtask

    task automatic t_reset();
        chk_eq("R1 redirect", 64'(fetch_redirect), 0);
        chk_eq("R1 busy", 64'(busy), 0);
        chk_eq("R1 valid", 64'(valid_out), 0);
        chk_eq("R1 addr", fetch_addr, 0);
        chk_eq("R1 mode", 64'(mode_now()), 0);
    endtask

    task automatic t_mispredict_rel();
        op_valid = 1; cur_nia = 64'h1000; br_resolve = 1; br_taken = 1;
        br_pred_taken = 0; br_operand = 64'hFFFF_FFFF_FFFF_FFE0;
        @(negedge clk);
        chk_eq("R2 redirect", 64'(fetch_redirect), 1);
        chk_eq("R2 addr", fetch_addr, 64'h0FE0);
        chk_eq("R11 busy", 64'(busy), 1);
        chk_eq("R11 valid squashed", 64'(valid_out), 0);
        idle();
        @(negedge clk);
        chk_eq("R11 one cycle", 64'(fetch_redirect), 0);
        chk_eq("R11 busy drops", 64'(busy), 0);
        op_valid = 1; cur_nia = 64'h1100;
        @(negedge clk);
        chk_eq("R11 valid passes", 64'(valid_out), 1);
        chk_eq("R11 no redirect", 64'(fetch_redirect), 0);
        idle();
    endtask

    task automatic t_mispredict_abs();
        op_valid = 1; cur_nia = 64'h3000; br_resolve = 1; br_taken = 1;
        br_pred_taken = 0; br_abs = 1; br_operand = 64'h8000_0000_0000_1234;
        @(negedge clk);
        chk_eq("R3 redirect", 64'(fetch_redirect), 1);
        chk_eq("R3 addr", fetch_addr, 64'h8000_0000_0000_1234);
        idle();
    endtask

    task automatic t_pred_taken();
        op_valid = 1; cur_nia = 64'h2000; br_resolve = 1; br_taken = 0;
        br_pred_taken = 1; br_operand = 64'h5555; br_abs = 1;
        @(negedge clk);
        chk_eq("R4 redirect", 64'(fetch_redirect), 1);
        chk_eq("R4 addr", fetch_addr, 64'h2004);
        idle();
        op_valid = 1; cur_nia = 64'h2400; br_resolve = 1; br_taken = 1;
        br_pred_taken = 1; br_operand = 64'h40;
        @(negedge clk);
        chk_eq("R4 correct prediction no redirect", 64'(fetch_redirect), 0);
        chk_eq("R4 valid", 64'(valid_out), 1);
        idle();
    endtask

    task automatic t_csync();
        op_valid = 1; cur_nia = 64'h4000; csync_req = 1;
        @(negedge clk);
        chk_eq("R5 redirect", 64'(fetch_redirect), 1);
        chk_eq("R5 addr", fetch_addr, 64'h4004);
        idle();
        op_valid = 1; cur_nia = 64'hFFFF_FFFF_FFFF_FFFC; csync_req = 1;
        @(negedge clk);
        chk_eq("R5 wrap", fetch_addr, 64'h0);
        idle();
    endtask

    task automatic t_modes();
        cur_ir = 1; cur_pr = 0; cur_le = 1; cur_sf = 1;
        @(negedge clk);
        chk_eq("R6 mode a", 64'(mode_now()), 64'({1'b1, 1'b1, 1'b0, 1'b0}));
        cur_ir = 0; cur_pr = 1; cur_le = 0; cur_sf = 0;
        @(negedge clk);
        chk_eq("R6 mode b", 64'(mode_now()), 64'({1'b0, 1'b0, 1'b1, 1'b1}));
        cur_ir = 0; cur_pr = 0; cur_le = 0; cur_sf = 1;
        @(negedge clk);
        chk_eq("R6 mode c", 64'(mode_now()), 64'({1'b0, 1'b1, 1'b1, 1'b0}));
    endtask

    task automatic t_rfi();
        op_valid = 1; cur_nia = 64'h5000; rfi_req = 1; rfi_addr = 64'h0000_7000_0000_0A00;
        rfi_ir = 0; rfi_pr = 1; rfi_le = 0; rfi_sf = 0;
        @(negedge clk);
        chk_eq("R7 redirect", 64'(fetch_redirect), 1);
        chk_eq("R7 addr", fetch_addr, 64'h0000_7000_0000_0A00);
        chk_eq("R7 mode", 64'(mode_now()), 64'({1'b1, 1'b0, 1'b1, 1'b1}));
        idle();
        op_valid = 1; rfi_req = 1; rfi_addr = 64'h10; rfi_ir = 1; rfi_pr = 0;
        rfi_le = 1; rfi_sf = 1;
        @(negedge clk);
        chk_eq("R7 mode 2", 64'(mode_now()), 64'({1'b1, 1'b1, 1'b0, 1'b0}));
        idle();
    endtask

    function automatic logic [63:0] exp_vec(input int c);
        case (c)
            1: return 64'h800;  2: return 64'hC00;  3: return 64'hD00;
            4: return 64'h600;  5: return 64'h300;  6: return 64'h380;
            7: return 64'h400;  8: return 64'h480;
            default: return 64'h700;
        endcase
    endfunction

    task automatic t_sync_vectors();
        cur_ir = 1; cur_pr = 1; cur_le = 1; cur_sf = 1;
        for (int c = 0; c < 16; c++) begin
            exc_req = 1; exc_cause = 4'(c);
            @(negedge clk);
            chk_eq($sformatf("R8 vector cause %0d", c), fetch_addr, exp_vec(c));
            chk_eq($sformatf("R8 forced mode cause %0d", c), 64'(mode_now()),
                   64'({1'b0, 1'b1, 1'b0, 1'b0}));
            idle();
            @(negedge clk);
        end
        cur_ir = 0; cur_pr = 0; cur_le = 0; cur_sf = 0;
    endtask

    task automatic t_async();
        cur_ee = 1; dec_top = 1; ext_irq = 1;
        @(negedge clk);
        chk_eq("R9 decrementer wins", fetch_addr, 64'h900);
        chk_eq("R9 redirect", 64'(fetch_redirect), 1);
        idle();
        ext_irq = 1;
        @(negedge clk);
        chk_eq("R9 external", fetch_addr, 64'h500);
        idle();
        cur_ee = 0; dec_top = 1; ext_irq = 1;
        @(negedge clk);
        chk_eq("R9 disabled ignored", 64'(fetch_redirect), 0);
        chk_eq("R9 disabled busy", 64'(busy), 0);
        idle();
    endtask

    task automatic t_precedence();
        op_valid = 1; cur_nia = 64'h6000; br_resolve = 1; br_taken = 1;
        br_pred_taken = 0; br_operand = 64'h100; exc_req = 1; exc_cause = 4'd2;
        @(negedge clk);
        chk_eq("R10 exception over mispredict", fetch_addr, 64'hC00);
        idle();
        cur_ee = 1; dec_top = 1; op_valid = 1; cur_nia = 64'h6100; csync_req = 1;
        @(negedge clk);
        chk_eq("R10 async over csync", fetch_addr, 64'h900);
        idle(); cur_ee = 0;
        op_valid = 1; cur_nia = 64'h6200; rfi_req = 1; rfi_addr = 64'hABC0;
        csync_req = 1; br_resolve = 1; br_taken = 1;
        @(negedge clk);
        chk_eq("R10 rfi over csync", fetch_addr, 64'hABC0);
        idle();
        op_valid = 1; cur_nia = 64'h6300; csync_req = 1; br_resolve = 1;
        br_taken = 1; br_operand = 64'h800;
        @(negedge clk);
        chk_eq("R10 csync over mispredict", fetch_addr, 64'h6304);
        idle();
    endtask

    initial begin
        idle();
        cur_ir = 0; cur_pr = 0; cur_le = 0; cur_sf = 0; cur_ee = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_mispredict_rel();
        t_mispredict_abs();
        t_pred_taken();
        t_csync();
        t_modes();
        t_rfi();
        t_sync_vectors();
        t_async();
        t_precedence();
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule